// File: doc/BRIEF.md
# Sampling Converter Serial Read Port

This block is a synthesizable digital model of the serial side of a 12-bit sampling converter. A host reads it over a three-wire, read-only port: an active-low frame select, a serial clock and one data line. A parallel sample input stands in for the analog core. The model captures that sample when the frame opens and sends it out as a framed serial word. Every port input is sampled on a fast system clock, so the serial clock and the frame select are treated as slow, synchronous levels, and the block acts on their edges.

A frame is sixteen serial clock cycles long. It holds a zero, the twelve result bits in straight binary with the most significant bit first, and two more zeros. The data line changes only after falling serial clock edges, and it is released from the 16th cycle onward. The block also keeps a power state. Releasing the frame select too early aborts the frame and puts the model to sleep. The next frame is then a dummy wake-up conversion, and its data is flagged as not valid. A short-frame option keeps the data line driven between back-to-back 14-cycle frames.

Top module: `sp_adc_port`

## Requirements
- R1: While reset is asserted, and just after it, `dout_oe`, `power_down` and `data_valid` are 0 and `dout` is 0.
- R2: A falling `cs_n` opens a frame. It latches `sample_in`, sets `dout_oe` to 1 and drives `dout` to 0 for the leading zero.
- R3: After falling serial clock edge k of a frame, for k from 1 to 12, `dout` carries bit 12-k of the latched sample. The MSB appears after edge 1 and the LSB after edge 12. After edges 13 and 14, `dout` is 0.
- R4: From the 15th falling edge onward `dout_oe` is 0, however many further edges arrive, up to at least 40. The edge count saturates and never wraps.
- R5: While `cs_n` is high and `short_mode` is 0, `dout_oe` is 0.
- R6: Raising `cs_n` after 2 to 9 falling edges aborts the frame. `dout_oe` goes to 0, `power_down` goes to 1 and `data_valid` goes to 0.
- R7: Raising `cs_n` after 10 or more falling edges leaves `power_down` at 0, or clears it.
- R8: `data_valid` is set when a frame opens, to 1 when the model is awake and to 0 when it is powered down. A frame opened while powered down is a dummy conversion. The frame after a completed dummy conversion has `data_valid` at 1.
- R9: With `short_mode` at 1, raising `cs_n` after 10 to 14 falling edges keeps `dout_oe` at 1 with `dout` at 0. This lasts until the next frame opens or `short_mode` falls.
- R10: Raising `cs_n` after fewer than 2 falling edges leaves `power_down` and `data_valid` unchanged.
- R11: Changes on `sample_in` after a frame opens do not alter the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every port input |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock level; falling edges advance the frame |
| short_mode | input | 1 | Keeps the data line driven between short frames |
| sample_in | input | 12 | Parallel sample that stands in for the converter core |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Data line drive enable (0 means high impedance) |
| power_down | output | 1 | 1 while the model is in the sleep state |
| data_valid | output | 1 | 1 when the current or last frame carries a real result |

## Verification
The hardest state to reach is a valid frame just after wake-up. The stimulus must first abort a frame inside the 2-to-9 edge window. It must then run a dummy frame, whose data is flagged invalid, for at least ten edges, and only then read a real result. The table of vectors walks through this chain several times: it aborts at the lower boundary of the window, retries a dummy frame that is one edge short, and wakes on exactly ten edges. Directed tests then push a frame far past sixteen edges to show the data line stays released, and drop the short-frame option while the line is still held.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int SMP_W      = 12;
    localparam int LEAD_Z     = 1;
    localparam int FRAME_LEN  = 16;
    localparam int ABORT_LO   = 2;
    localparam int WAKE_MIN   = 10;

    typedef enum logic {
        PWR_NORMAL = 1'b0,
        PWR_DOWN   = 1'b1
    } pwr_e;

    typedef enum logic [1:0] {
        REL_EARLY = 2'd0,
        REL_ABORT = 2'd1,
        REL_FULL  = 2'd2
    } rel_e;

    typedef struct packed {
        logic cs_rise;
        logic cs_fall;
        logic sclk_fall;
    } port_ev_t;

    function automatic rel_e classify(input int unsigned n,
                                      input int unsigned lo,
                                      input int unsigned hi);
        if (n < lo)      return REL_EARLY;
        else if (n < hi) return REL_ABORT;
        else             return REL_FULL;
    endfunction

endpackage

// File: rtl/sp_edge.sv
module sp_edge #(
    parameter int           N       = 3,
    parameter logic [N-1:0] FALLING = '1,
    parameter logic [N-1:0] IDLE    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] ev
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;

        always_ff @(posedge clk) begin
            if (rst) q <= IDLE[i];
            else     q <= sig[i];
        end

        if (FALLING[i]) begin : g_fall
            assign ev[i] = q & ~sig[i];
        end else begin : g_rise
            assign ev[i] = ~q & sig[i];
        end
    end

endmodule

// File: rtl/sp_frame.sv
module sp_frame
    import sp_pkg::*;
#(
    parameter int DATA_W   = SMP_W,
    parameter int LEAD     = LEAD_Z,
    parameter int FRM_CYC  = FRAME_LEN,
    parameter int WAKE_E   = WAKE_MIN,
    parameter int CNT_W    = $clog2(FRM_CYC) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  port_ev_t          ev,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              short_mode,
    output logic [CNT_W-1:0]  cnt,
    output logic              active,
    output logic              dout,
    output logic              dout_oe
);

    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] LEAD_C     = CNT_W'(LEAD);
    localparam logic [CNT_W-1:0] DATA_END   = CNT_W'(LEAD + DATA_W);
    localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(FRM_CYC - 2);
    localparam logic [CNT_W-1:0] WAKE_C     = CNT_W'(WAKE_E);

    logic [DATA_W-1:0] smp_q;
    logic [DATA_W-1:0] shifted;
    logic              hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q  <= '0;
            cnt    <= '0;
            active <= 1'b0;
            hold_q <= 1'b0;
        end else if (ev.cs_fall) begin
            smp_q  <= sample_in;
            cnt    <= '0;
            active <= 1'b1;
            hold_q <= 1'b0;
        end else if (ev.cs_rise) begin
            active <= 1'b0;
            hold_q <= active && short_mode && (cnt >= WAKE_C) && (cnt <= DRIVE_LAST);
        end else if (ev.sclk_fall && active) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        shifted = smp_q << (cnt - LEAD_C);
        dout_oe = (active && (cnt <= DRIVE_LAST)) || (hold_q && short_mode);
        dout    = 1'b0;
        if (active && (cnt >= LEAD_C) && (cnt < DATA_END))
            dout = shifted[DATA_W-1];
    end

endmodule

// File: rtl/sp_power.sv
module sp_power
    import sp_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int ABORT  = ABORT_LO,
    parameter int WAKE_E = WAKE_MIN
) (
    input  logic             clk,
    input  logic             rst,
    input  port_ev_t         ev,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    output logic             power_down,
    output logic             data_valid
);

    pwr_e pwr_q;
    rel_e kind;

    assign kind       = classify(int'(cnt), ABORT, WAKE_E);
    assign power_down = (pwr_q == PWR_DOWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q      <= PWR_NORMAL;
            data_valid <= 1'b0;
        end else if (ev.cs_fall) begin
            data_valid <= (pwr_q == PWR_NORMAL);
        end else if (ev.cs_rise && active) begin
            case (kind)
                REL_ABORT: begin
                    pwr_q      <= PWR_DOWN;
                    data_valid <= 1'b0;
                end
                REL_FULL:  pwr_q <= PWR_NORMAL;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/sp_adc_port.sv
module sp_adc_port
    import sp_pkg::*;
#(
    parameter int DATA_W  = SMP_W,
    parameter int LEAD    = LEAD_Z,
    parameter int FRM_CYC = FRAME_LEN,
    parameter int ABORT   = ABORT_LO,
    parameter int WAKE_E  = WAKE_MIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              short_mode,
    input  logic [DATA_W-1:0] sample_in,
    output logic              dout,
    output logic              dout_oe,
    output logic              power_down,
    output logic              data_valid
);

    localparam int CNT_W = $clog2(FRM_CYC) + 1;

    logic [2:0]       ev_vec;
    port_ev_t         ev;
    logic [CNT_W-1:0] cnt;
    logic             active;

    sp_edge #(
        .N       (3),
        .FALLING (3'b011),
        .IDLE    (3'b110)
    ) u_edge (
        .clk (clk),
        .rst (rst),
        .sig ({cs_n, cs_n, sclk}),
        .ev  (ev_vec)
    );

    assign ev = ev_vec;

    sp_frame #(
        .DATA_W  (DATA_W),
        .LEAD    (LEAD),
        .FRM_CYC (FRM_CYC),
        .WAKE_E  (WAKE_E),
        .CNT_W   (CNT_W)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .sample_in  (sample_in),
        .short_mode (short_mode),
        .cnt        (cnt),
        .active     (active),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    sp_power #(
        .CNT_W  (CNT_W),
        .ABORT  (ABORT),
        .WAKE_E (WAKE_E)
    ) u_power (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .active     (active),
        .cnt        (cnt),
        .power_down (power_down),
        .data_valid (data_valid)
    );

endmodule

// File: rtl/sp_adc_port_chk.sv
module sp_adc_port_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic short_mode,
    input logic dout,
    input logic dout_oe,
    input logic power_down,
    input logic data_valid
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!dout_oe && !power_down && !data_valid && !dout)); // R1

    AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> (dout_oe && !dout)); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && !short_mode) |-> !dout_oe); // R5

    AST_SLEEP_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(power_down) |-> ($past(cs_n) && !dout_oe && !data_valid)); // R6

    AST_SLEEP_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        power_down |-> !data_valid); // R8

endmodule

bind sp_adc_port sp_adc_port_chk u_chk (.*);

// File: tb/tb_sp_adc_port.sv
module tb_sp_adc_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        short_mode = 1'b0;
    logic [11:0] sample_in = '0;
    logic        dout, dout_oe, power_down, data_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sp_adc_port dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .short_mode(short_mode), .sample_in(sample_in),
        .dout(dout), .dout_oe(dout_oe),
        .power_down(power_down), .data_valid(data_valid)
    );

    // [18:7] sample, [6:2] falling edges before release, [1] short_mode, [0] expected power_down
    localparam logic [18:0] VEC [14] = '{
        {12'hA5C, 5'd16, 1'b0, 1'b0},
        {12'hFFF, 5'd16, 1'b0, 1'b0},
        {12'h000, 5'd12, 1'b0, 1'b0},
        {12'h123, 5'd5,  1'b0, 1'b1},
        {12'h456, 5'd16, 1'b0, 1'b0},
        {12'h789, 5'd16, 1'b0, 1'b0},
        {12'h3C3, 5'd2,  1'b0, 1'b1},
        {12'h111, 5'd9,  1'b0, 1'b1},
        {12'h222, 5'd10, 1'b0, 1'b0},
        {12'h800, 5'd14, 1'b1, 1'b0},
        {12'h001, 5'd1,  1'b0, 1'b0},
        {12'h7FF, 5'd20, 1'b0, 1'b0},
        {12'h5A5, 5'd14, 1'b1, 1'b0},
        {12'hABC, 5'd13, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_edge();
        sclk = 1'b1; tick(1);
        sclk = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        bit pd_m;
        bit vd_m;
        tick(3);
        chk(!dout_oe && !dout, "R1 oe/dout in reset", dout_oe, 0);
        chk(!power_down && !data_valid, "R1 flags in reset", power_down + data_valid, 0);
        rst = 1'b0;
        tick(2);
        chk(!dout_oe && !power_down && !data_valid, "R1 after reset", dout_oe + power_down + data_valid, 0);

        pd_m = 1'b0;
        vd_m = 1'b0;
        foreach (VEC[v]) begin
            logic [11:0] s;
            int n;
            bit sh;
            bit hold_e;
            s  = VEC[v][18:7];
            n  = int'(VEC[v][6:2]);
            sh = VEC[v][1];
            short_mode = sh;
            sample_in = s;
            cs_n = 1'b0; tick(1);
            vd_m = !pd_m;
            chk(dout_oe && !dout, "R2 frame opens driving zero", dout_oe, 1);
            chk(data_valid == vd_m, "R8 valid at frame start", data_valid, vd_m);
            sample_in = ~s; // R11: must not disturb this frame
            for (int k = 1; k <= n; k++) begin
                bit oe_e;
                bit d_e;
                fall_edge();
                oe_e = (k <= 14);
                d_e  = (k >= 1 && k <= 12) ? s[12-k] : 1'b0;
                chk(dout_oe == oe_e, (k >= 15) ? "R4 released late in frame" : "R3 driven in frame", dout_oe, oe_e);
                if (vd_m && oe_e)
                    chk(dout == d_e, "R3 R11 serial bit", dout, d_e);
            end
            cs_n = 1'b1; tick(1);
            if (n >= 2 && n < 10) begin
                pd_m = 1'b1;
                vd_m = 1'b0;
            end else if (n >= 10) begin
                pd_m = 1'b0;
            end
            chk(power_down == VEC[v][0], "R6 R7 R10 table power state", power_down, VEC[v][0]);
            chk(power_down == pd_m, "R6 R7 R10 modelled power state", power_down, pd_m);
            chk(data_valid == vd_m, "R8 R10 valid after release", data_valid, vd_m);
            hold_e = sh && n >= 10 && n <= 14;
            tick(2);
            chk(dout_oe == hold_e, hold_e ? "R9 held between short frames" : "R5 released when idle", dout_oe, hold_e);
            if (hold_e) chk(!dout, "R9 held line is zero", dout, 0);
        end

        // R9: dropping short_mode releases a held line
        short_mode = 1'b0; tick(1);
        chk(!dout_oe, "R9 release on short_mode low", dout_oe, 0);

        // R4: long frame, count must not wrap
        cs_n = 1'b0; tick(1);
        for (int k = 1; k <= 40; k++) begin
            fall_edge();
            if (k >= 15) chk(!dout_oe, "R4 no wrap on long frame", dout_oe, 0);
        end
        cs_n = 1'b1; tick(2);
        chk(!power_down && data_valid, "R7 long frame keeps normal", power_down, 0);

        // R1: reset in the middle of a frame
        cs_n = 1'b0; tick(1);
        fall_edge(); fall_edge(); fall_edge();
        rst = 1'b1; cs_n = 1'b1; tick(2);
        chk(!dout_oe && !power_down && !data_valid, "R1 mid-frame reset", dout_oe + power_down + data_valid, 0);
        rst = 1'b0; tick(2);

        finish_run();
    end

endmodule